// File: doc/BRIEF.md
# Successive-Approximation Converter Sequencer with Byte/Word Bus Readout

This block is the digital half of a successive-approximation analog-to-digital converter that sits on a microprocessor bus. A chip-enable, an active-low chip-select, a read-or-convert line and one address bit are decoded on each clock. The result is either a new conversion or a read of the last result. The analog side is reduced to one comparator bit. It reports whether the trial code now on the `trialCode` output is at or below the sampled input. The sequencer resolves one bit per clock, starting at the most significant bit.

The address bit seen with the convert command picks the conversion length: a full run over every bit, or a short run over the upper byte only. A short run zeroes the unresolved low bits of the result. A static format input picks how the result is read out. It is either one parallel word, or two bytes that share the upper eight data lines, selected by the address bit. Tri-state drivers are modelled as one output enable per nibble of the data bus. A disabled line reads as zero.

Top module: `sarBusCtrl`

## Requirements
- R1: When `chipEn` is 0 or `chipSelN` is 1, no conversion starts, `busy` stays as it was when idle, and every bit of `nibbleOe` is 0.
- R2: With `chipEn`=1, `chipSelN`=0, `rdNotConv`=0 and `busy`=0 on a clock edge, the next cycle shows `busy`=1, `done8`=0, `done12`=0 and `trialCode` with only its MSB set (0x800).
- R3: With `addrBit`=0 at the convert command, the run makes 12 decisions, one per clock. Each decision keeps the trial bit when `cmpKeep`=1 and clears it otherwise. After the 12th decision edge `busy`=0 and the result equals the input code that the comparator models.
- R4: With `addrBit`=1 at the convert command, the run ends after 8 decisions. The result holds the 8 resolved upper bits, and its 4 low bits are 0.
- R5: `done8` returns to 1 on the 8th decision edge. In a full run `done12` stays 0 until the 12th decision edge. In every run `done12` returns to 1 exactly when `busy` returns to 0.
- R6: A convert command while `busy`=1 is ignored. The running conversion keeps its length and end time, and the stored result changes only on the final decision edge.
- R7: While `busy`=1, a read enables no output nibble (`nibbleOe`=0).
- R8: With `wordMode`=1, an idle read enables all three nibbles (`nibbleOe`=3'b111) and drives the 12-bit result on `dataBus`, whatever `addrBit` is.
- R9: With `wordMode`=0 and `addrBit`=0, an idle read sets `nibbleOe`=3'b110 and drives result bits 11..4 on `dataBus[11:4]`. `dataBus[3:0]` reads 0.
- R10: With `wordMode`=0 and `addrBit`=1, an idle read sets `nibbleOe`=3'b110 and drives result bits 3..0 on `dataBus[11:8]`. `dataBus[7:0]` reads 0.
- R11: Synchronous active-high `rst` clears the result to 0 and sets `busy`=0, `done8`=1 and `done12`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chipEn | input | 1 | Chip enable, active high |
| chipSelN | input | 1 | Chip select, active low |
| rdNotConv | input | 1 | 1 = read result, 0 = start conversion |
| addrBit | input | 1 | Conversion length at convert (0 full, 1 short); byte select at read |
| wordMode | input | 1 | Static format: 1 = 12-bit word, 0 = two bytes |
| cmpKeep | input | 1 | Comparator: trial code is at or below the input |
| trialCode | output | 12 | Current trial code for the DAC |
| busy | output | 1 | High while a conversion runs |
| done8 | output | 1 | Low from convert start until 8 bits are resolved |
| done12 | output | 1 | Low from convert start until the conversion completes |
| dataBus | output | 12 | Read data; 0 on disabled nibbles |
| nibbleOe | output | 3 | Per-nibble output enable; bit 2 = lines 11..8 |

## Verification
The bench uses the default build: 12 full bits, an 8-bit short run, and nibble-wide enables. At these values both run lengths, the `done8`/`done12` split and the overlap of the byte reads onto the upper lines are all reached. A comparator model built from a random target code drives every bit position to both decisions. Directed codes 0x000, 0xFFF, 0x800 and codes with nonzero low nibbles show the short-run truncation. Convert commands injected mid-run, and reads during a run, show the busy interlock.

// File: rtl/sarPkg.sv
package sarPkg;
  localparam int unsigned FULL_BITS  = 12;
  localparam int unsigned SHORT_BITS = 8;
  localparam int unsigned NIB_W      = 4;
  localparam int unsigned NIB_CNT    = FULL_BITS / NIB_W;
  localparam int unsigned LOW_BITS   = FULL_BITS - SHORT_BITS;
  localparam int unsigned CNT_W      = $clog2(FULL_BITS + 1);

  typedef enum logic {ST_IDLE, ST_CONV} sarState_t;

  typedef struct packed {
    logic start;
    logic decide;
    logic finish;
    logic shortMode;
  } sarStrobe_t;
endpackage

// File: rtl/sarControl.sv
module sarControl
  import sarPkg::*;
#(
  parameter int unsigned FULL_W  = sarPkg::FULL_BITS,
  parameter int unsigned SHORT_W = sarPkg::SHORT_BITS,
  parameter int unsigned CW      = sarPkg::CNT_W
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       chipEn,
  input  logic       chipSelN,
  input  logic       rdNotConv,
  input  logic       addrBit,
  output sarStrobe_t strobe,
  output logic       busy,
  output logic       done8,
  output logic       done12,
  output logic       readEn
);
  localparam logic [CW-1:0] FULL_CNT  = CW'(FULL_W);
  localparam logic [CW-1:0] SHORT_CNT = CW'(SHORT_W);

  sarState_t     stateQ;
  logic [CW-1:0] decCntQ;
  logic [CW-1:0] nextCnt;
  logic [CW-1:0] lastCnt;
  logic          shortQ;
  logic          selected;
  logic          convReq;
  logic          readReq;

  // Bus decode: nothing happens unless the part is both enabled and selected
  assign selected = chipEn & ~chipSelN;
  assign convReq  = selected & ~rdNotConv;
  assign readReq  = selected & rdNotConv;

  assign busy    = (stateQ == ST_CONV);
  assign readEn  = readReq & ~busy;
  assign nextCnt = decCntQ + 1'b1;
  assign lastCnt = shortQ ? SHORT_CNT : FULL_CNT;

  always_comb begin
    strobe.start     = (stateQ == ST_IDLE) & convReq;
    strobe.decide    = (stateQ == ST_CONV);
    strobe.finish    = (stateQ == ST_CONV) & (nextCnt == lastCnt);
    strobe.shortMode = shortQ;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stateQ  <= ST_IDLE;
      decCntQ <= '0;
      shortQ  <= 1'b0;
      done8   <= 1'b1;
      done12  <= 1'b1;
    end else begin
      case (stateQ)
        ST_IDLE: begin
          if (strobe.start) begin
            stateQ  <= ST_CONV;
            decCntQ <= '0;
            shortQ  <= addrBit;
            done8   <= 1'b0;
            done12  <= 1'b0;
          end
        end
        ST_CONV: begin
          decCntQ <= nextCnt;
          if (nextCnt == SHORT_CNT) done8 <= 1'b1;
          if (strobe.finish) begin
            stateQ <= ST_IDLE;
            done12 <= 1'b1;
          end
        end
        default: stateQ <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sarDatapath.sv
module sarDatapath
  import sarPkg::*;
#(
  parameter int unsigned FULL_W  = sarPkg::FULL_BITS,
  parameter int unsigned SHORT_W = sarPkg::SHORT_BITS,
  parameter int unsigned NW      = sarPkg::NIB_W,
  parameter int unsigned NCNT    = sarPkg::NIB_CNT
) (
  input  logic              clk,
  input  logic              rst,
  input  sarStrobe_t        strobe,
  input  logic              cmpKeep,
  input  logic              readEn,
  input  logic              addrBit,
  input  logic              wordMode,
  output logic [FULL_W-1:0] trialCode,
  output logic [FULL_W-1:0] resultQ,
  output logic [FULL_W-1:0] dataBus,
  output logic [NCNT-1:0]   nibbleOe
);
  localparam int unsigned LOW_W = FULL_W - SHORT_W;
  localparam int unsigned LOW_NIB = LOW_W / NW;
  localparam logic [FULL_W-1:0] MSB_ONE  = {1'b1, {(FULL_W-1){1'b0}}};
  localparam logic [FULL_W-1:0] LOW_MASK = {{SHORT_W{1'b0}}, {LOW_W{1'b1}}};

  logic [FULL_W-1:0]  trialQ;
  logic [FULL_W-1:0]  maskQ;
  logic [FULL_W-1:0]  decided;
  logic [FULL_W-1:0]  nextTrial;
  logic [FULL_W-1:0]  finalVal;
  logic [SHORT_W-1:0] byteVal;
  logic [FULL_W-1:0]  busRaw;

  // One decision per clock on the bit marked by maskQ
  always_comb begin
    decided   = (trialQ & ~maskQ) | (cmpKeep ? maskQ : '0);
    nextTrial = strobe.finish ? decided : (decided | (maskQ >> 1));
    finalVal  = strobe.shortMode ? (decided & ~LOW_MASK) : decided;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      trialQ  <= '0;
      maskQ   <= '0;
      resultQ <= '0;
    end else if (strobe.start) begin
      trialQ <= MSB_ONE;
      maskQ  <= MSB_ONE;
    end else if (strobe.decide) begin
      trialQ <= nextTrial;
      maskQ  <= maskQ >> 1;
      if (strobe.finish) resultQ <= finalVal;
    end
  end

  assign trialCode = trialQ;

  // Byte reads overlap onto the upper SHORT_W lines
  always_comb begin
    if (addrBit) byteVal = {resultQ[LOW_W-1:0], {(SHORT_W-LOW_W){1'b0}}};
    else         byteVal = resultQ[FULL_W-1:LOW_W];
    busRaw  = wordMode ? resultQ : {byteVal, {LOW_W{1'b0}}};
    dataBus = readEn ? busRaw : '0;
  end

  for (genvar g = 0; g < NCNT; g++) begin : g_nibOe
    if (g >= LOW_NIB) begin : g_upper
      assign nibbleOe[g] = readEn;
    end else begin : g_lower
      assign nibbleOe[g] = readEn & wordMode;
    end
  end
endmodule

// File: rtl/sarBusCtrl.sv
module sarBusCtrl
  import sarPkg::*;
#(
  parameter int unsigned FULL_W  = sarPkg::FULL_BITS,
  parameter int unsigned SHORT_W = sarPkg::SHORT_BITS,
  parameter int unsigned NW      = sarPkg::NIB_W,
  parameter int unsigned NCNT    = FULL_W / NW,
  parameter int unsigned CW      = $clog2(FULL_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              chipEn,
  input  logic              chipSelN,
  input  logic              rdNotConv,
  input  logic              addrBit,
  input  logic              wordMode,
  input  logic              cmpKeep,
  output logic [FULL_W-1:0] trialCode,
  output logic              busy,
  output logic              done8,
  output logic              done12,
  output logic [FULL_W-1:0] dataBus,
  output logic [NCNT-1:0]   nibbleOe
);
  sarStrobe_t        strobe;
  logic              readEn;
  logic [FULL_W-1:0] resultQ;

  sarControl #(.FULL_W(FULL_W), .SHORT_W(SHORT_W), .CW(CW)) i_ctrl (
    .clk      (clk),
    .rst      (rst),
    .chipEn   (chipEn),
    .chipSelN (chipSelN),
    .rdNotConv(rdNotConv),
    .addrBit  (addrBit),
    .strobe   (strobe),
    .busy     (busy),
    .done8    (done8),
    .done12   (done12),
    .readEn   (readEn)
  );

  sarDatapath #(.FULL_W(FULL_W), .SHORT_W(SHORT_W), .NW(NW), .NCNT(NCNT)) i_dp (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .cmpKeep  (cmpKeep),
    .readEn   (readEn),
    .addrBit  (addrBit),
    .wordMode (wordMode),
    .trialCode(trialCode),
    .resultQ  (resultQ),
    .dataBus  (dataBus),
    .nibbleOe (nibbleOe)
  );
endmodule

// File: rtl/sarChecker.sv
module sarChecker #(
  parameter int unsigned FULL_W = 12,
  parameter int unsigned NCNT   = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              chipEn,
  input logic              chipSelN,
  input logic              rdNotConv,
  input logic              busy,
  input logic              done8,
  input logic              done12,
  input logic [FULL_W-1:0] trialCode,
  input logic [FULL_W-1:0] resultQ,
  input logic [NCNT-1:0]   nibbleOe
);
  localparam logic [FULL_W-1:0] MSB_ONE = {1'b1, {(FULL_W-1){1'b0}}};

  AST_NO_START_UNSELECTED: assert property (@(posedge clk) disable iff (rst)
    ((!chipEn || chipSelN) && !busy) |=> !busy); // R1
  AST_NO_OE_UNSELECTED: assert property (@(posedge clk) disable iff (rst)
    (!chipEn || chipSelN) |-> (nibbleOe == '0)); // R1
  AST_START_MSB: assert property (@(posedge clk) disable iff (rst)
    (chipEn && !chipSelN && !rdNotConv && !busy)
      |=> (busy && trialCode == MSB_ONE && !done8 && !done12)); // R2
  AST_DONE_ORDER: assert property (@(posedge clk) disable iff (rst)
    done12 |-> done8); // R5
  AST_BUSY_DONE12: assert property (@(posedge clk) disable iff (rst)
    busy != done12); // R5
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
    ($past(busy) && busy) |-> $stable(resultQ)); // R6
  AST_NO_OE_BUSY: assert property (@(posedge clk) disable iff (rst)
    busy |-> (nibbleOe == '0)); // R7
endmodule

bind sarBusCtrl sarChecker #(.FULL_W(FULL_W), .NCNT(NCNT)) i_sarChecker (
  .clk      (clk),
  .rst      (rst),
  .chipEn   (chipEn),
  .chipSelN (chipSelN),
  .rdNotConv(rdNotConv),
  .busy     (busy),
  .done8    (done8),
  .done12   (done12),
  .trialCode(trialCode),
  .resultQ  (resultQ),
  .nibbleOe (nibbleOe)
);

// File: tb/test_sarBusCtrl.sv
module test_sarBusCtrl;
  logic        clk = 1'b0;
  logic        rst;
  logic        chipEn, chipSelN, rdNotConv, addrBit, wordMode, cmpKeep;
  logic [11:0] trialCode, dataBus, analogVal;
  logic        busy, done8, done12;
  logic [2:0]  nibbleOe;
  int          checks = 0;
  int          fails = 0;

  always #5 clk = ~clk;

  // Comparator model: trial code at or below the target keeps the bit
  assign cmpKeep = (trialCode <= analogVal);

  sarBusCtrl i_sarBusCtrl (
    .clk(clk), .rst(rst), .chipEn(chipEn), .chipSelN(chipSelN),
    .rdNotConv(rdNotConv), .addrBit(addrBit), .wordMode(wordMode),
    .cmpKeep(cmpKeep), .trialCode(trialCode), .busy(busy), .done8(done8),
    .done12(done12), .dataBus(dataBus), .nibbleOe(nibbleOe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] expResult(input logic [11:0] v, input logic isShort);
    return isShort ? {v[11:4], 4'h0} : v;
  endfunction

  function automatic logic [11:0] expBus(input logic [11:0] r, input logic w, input logic a);
    if (w) return r;
    return a ? {r[3:0], 8'h00} : {r[11:4], 4'h0};
  endfunction

  function automatic logic [2:0] expOe(input logic w);
    return w ? 3'b111 : 3'b110;
  endfunction

  task automatic idleBus();
    chipEn = 1'b0; chipSelN = 1'b1; rdNotConv = 1'b1; addrBit = 1'b0;
  endtask

  task automatic readChk(input logic w, input logic a, input logic [11:0] res, input string req);
    @(negedge clk);
    wordMode = w; chipEn = 1'b1; chipSelN = 1'b0; rdNotConv = 1'b1; addrBit = a;
    #1;
    chk({req, " oe"}, 32'(nibbleOe), 32'(expOe(w)));
    chk({req, " data"}, 32'(dataBus), 32'(expBus(res, w, a)));
    idleBus();
  endtask

  // Full conversion; injectAt>0 drives a convert command before that decision edge
  task automatic runConv(input logic isShort, input logic [11:0] v, input int injectAt);
    int n = isShort ? 8 : 12;
    @(negedge clk);
    analogVal = v;
    chipEn = 1'b1; chipSelN = 1'b0; rdNotConv = 1'b0; addrBit = isShort;
    @(negedge clk);
    idleBus();
    chk("R2 busy", 32'(busy), 1);
    chk("R2 trial", 32'(trialCode), 32'h800);
    chk("R2 done", 32'({done8, done12}), 0);
    for (int k = 1; k <= n; k++) begin
      if (k == injectAt) begin
        chipEn = 1'b1; chipSelN = 1'b0; rdNotConv = 1'b0; addrBit = ~isShort;
      end
      @(negedge clk);
      idleBus();
      if (k == injectAt + 1 && injectAt > 0) begin
        chipEn = 1'b1; chipSelN = 1'b0; rdNotConv = 1'b1; wordMode = 1'b1;
        #1;
        chk("R7 oe during busy", 32'(nibbleOe), 0);
        idleBus();
      end
      if (k == 8) chk("R5 done8 at 8", 32'(done8), 1);
      if (k == 8 && !isShort) chk("R5 done12 low at 8", 32'(done12), 0);
      if (k < n) chk(injectAt > 0 ? "R6 still busy" : "R3 busy", 32'(busy), 1);
    end
    chk(isShort ? "R4 end" : "R3 end", 32'({busy, done12}), 32'b01);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [11:0] v;
    logic s, w, a;
    void'($urandom(32'd1234));
    idleBus(); wordMode = 1'b1; analogVal = '0; rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    chk("R11 busy", 32'(busy), 0);
    chk("R11 done", 32'({done8, done12}), 32'b11);
    readChk(1'b1, 1'b0, 12'h000, "R11 result");

    runConv(1'b0, 12'hA5C, 0);
    readChk(1'b1, 1'b1, 12'hA5C, "R8 word");
    readChk(1'b0, 1'b0, 12'hA5C, "R9 high byte");
    readChk(1'b0, 1'b1, 12'hA5C, "R10 low byte");

    // R1: unselected convert attempts do nothing
    @(negedge clk); chipEn = 1'b0; chipSelN = 1'b0; rdNotConv = 1'b0;
    @(negedge clk); chk("R1 chipEn low", 32'(busy), 0);
    chipEn = 1'b1; chipSelN = 1'b1;
    @(negedge clk); chk("R1 chipSelN high", 32'(busy), 0);
    rdNotConv = 1'b1; #1; chk("R1 read unselected", 32'(nibbleOe), 0);
    idleBus();
    readChk(1'b1, 1'b0, 12'hA5C, "R1 result kept");

    runConv(1'b0, 12'h000, 0); readChk(1'b1, 1'b0, 12'h000, "R3 zero");
    runConv(1'b0, 12'hFFF, 0); readChk(1'b1, 1'b0, 12'hFFF, "R3 full");
    runConv(1'b0, 12'h800, 0); readChk(1'b1, 1'b0, 12'h800, "R3 mid");
    runConv(1'b1, 12'hABC, 0); readChk(1'b1, 1'b0, 12'hAB0, "R4 short");
    readChk(1'b0, 1'b1, 12'hAB0, "R4 low byte zero");
    runConv(1'b1, 12'hFFF, 0); readChk(1'b1, 1'b0, 12'hFF0, "R4 short full");
    runConv(1'b0, 12'h3C7, 3); readChk(1'b1, 1'b0, 12'h3C7, "R6 ignored cmd");
    runConv(1'b1, 12'h5E9, 2); readChk(1'b1, 1'b0, 12'h5E0, "R6 ignored in short");

    for (int i = 0; i < 40; i++) begin
      v = 12'($urandom); s = 1'($urandom); w = 1'($urandom); a = 1'($urandom);
      runConv(s, v, (i % 4 == 0) ? 1 + int'($urandom % 6) : 0);
      readChk(w, a, expResult(v, s), s ? "R4 random" : "R3 random");
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule